// File: doc/BRIEF.md
# Single-Bit Boolean Processor Unit

This block is the bit-manipulation engine of an 8-bit control processor. The carry flag acts as a one-bit accumulator. Each clock the block accepts one operation code together with an 8-bit bit address, the program counter of the following instruction and a signed 8-bit displacement. The operation either combines the carry with a selected bit, moves a bit between the carry and the bit space, or tests a bit to decide a relative branch.

A 256-entry bit array inside the block models the bit-addressable space, so the unit can run on its own. Bit writes appear on a strobe and data pair in the same cycle as the operation that causes them and take effect at the next rising edge. The carry also updates at that edge. The branch decision and the branch target are combinational outputs, valid in the same cycle as the operation. One operation, test-and-clear branch, both decides a branch and clears the tested bit. This gives atomic flag consumption, for example in a polling loop that must not lose an event.

Top module: `bool_bit_engine`

## Requirements
- R1: A synchronous active-high reset clears the carry and all 256 bits of the bit array.
- R2: Code 0 leaves the carry unchanged, code 1 sets it, code 2 clears it and code 3 inverts it. None of these codes writes a bit.
- R3: Code 4 loads the carry with carry AND bit. Code 5 loads the carry with carry AND the inverted bit.
- R4: Code 6 loads the carry with carry OR bit. Code 7 loads the carry with carry OR the inverted bit.
- R5: Code 8 copies the addressed bit into the carry. Code 9 writes the carry into the addressed bit, with `wb_en_o`=1 and `wb_bit_o` equal to the carry in that cycle.
- R6: Code 10 branches when the addressed bit is 1. Code 11 branches when it is 0. Neither code changes the carry or any bit.
- R7: Code 12 branches when the addressed bit is 1 and clears that bit in the same operation (`wb_en_o`=1, `wb_bit_o`=0). When the bit is 0 it neither branches nor writes.
- R8: `br_target_o` always equals `next_pc_i` plus the displacement, sign-extended to 16 bits, modulo 2^16. `br_taken_o` is 0 for every code other than 10, 11 and 12.
- R9: `wb_en_o` is 1 only for code 9 and for code 12 with a set bit. Codes 13 to 15 change neither the carry nor any bit.
- R10: The branch outputs and the write strobe depend only on the current inputs and state. A carry or bit update becomes visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code (see requirements) |
| bit_addr_i | input | 8 | Address of the selected bit |
| next_pc_i | input | 16 | Address of the following instruction |
| rel_off_i | input | 8 | Signed branch displacement |
| carry_o | output | 1 | Registered carry / Boolean accumulator |
| wb_en_o | output | 1 | Bit write-back strobe for this cycle |
| wb_bit_o | output | 1 | Value written to the addressed bit |
| br_taken_o | output | 1 | Branch decision |
| br_target_o | output | 16 | Relative branch destination |

## Verification
The bench targets test-and-clear on a set bit. A design that skips the clear would take the same branch again on the next test. A design that clears the bit without checking it would zero bits on a not-taken branch. Target arithmetic is checked at both 16-bit wrap points and with negative displacements, where zero-extending the displacement jumps forward by almost 256 instead of backward. The complemented AND and OR forms are run against set and clear bits to expose a swapped polarity. The unused codes and the branch codes run with the carry set, so that a decoder defaulting into a carry update would show the change. Bit writes at addresses 0 and 255 are read back through the carry to catch address truncation.

// File: rtl/bitproc_pkg.sv
`timescale 1ns/1ps
package bitproc_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_SETC  = 4'd1,
    OP_CLRC  = 4'd2,
    OP_CPLC  = 4'd3,
    OP_ANL   = 4'd4,
    OP_ANLN  = 4'd5,
    OP_ORL   = 4'd6,
    OP_ORLN  = 4'd7,
    OP_LDC   = 4'd8,
    OP_STC   = 4'd9,
    OP_JSET  = 4'd10,
    OP_JCLR  = 4'd11,
    OP_JSETC = 4'd12,
    OP_RSV13 = 4'd13,
    OP_RSV14 = 4'd14,
    OP_RSV15 = 4'd15
  } op_e;

  // Next value of the Boolean accumulator.
  function automatic logic f_next_carry(op_e op, logic c, logic b);
    logic n;
    case (op)
      OP_SETC: n = 1'b1;
      OP_CLRC: n = 1'b0;
      OP_CPLC: n = ~c;
      OP_ANL:  n = c & b;
      OP_ANLN: n = c & ~b;
      OP_ORL:  n = c | b;
      OP_ORLN: n = c | ~b;
      OP_LDC:  n = b;
      default: n = c;
    endcase
    return n;
  endfunction

  function automatic logic f_is_branch(op_e op);
    return (op == OP_JSET) || (op == OP_JCLR) || (op == OP_JSETC);
  endfunction

  // Whether the carry register is written at all.
  function automatic logic f_writes_carry(op_e op);
    return (op >= OP_SETC) && (op <= OP_LDC);
  endfunction

endpackage

// File: rtl/bit_store.sv
`timescale 1ns/1ps
module bit_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else if (wr_en) begin
      bits_q[wr_addr] <= wr_bit;
    end
  end

  assign rd_bit = bits_q[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (bits_q[$past(wr_addr)] == $past(wr_bit))) else $error("write lost"); // R5

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bits_q)) else $error("bit array changed without strobe"); // R9

endmodule

// File: rtl/carry_unit.sv
`timescale 1ns/1ps
module carry_unit
  import bitproc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_e  op,
  input  logic sel_bit,
  output logic carry_q
);
  logic carry_d;
  logic carry_we;

  assign carry_we = f_writes_carry(op);
  assign carry_d  = f_next_carry(op, carry_q, sel_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
    end else if (carry_we) begin
      carry_q <= carry_d;
    end
  end

  AST_CPL_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CPLC) |=> (carry_q != $past(carry_q))) else $error("complement failed"); // R2

  AST_SET_ONE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SETC) |=> carry_q) else $error("set failed"); // R2

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LDC) |=> (carry_q == $past(sel_bit))) else $error("load failed"); // R5

  AST_BRANCH_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
    f_is_branch(op) |=> $stable(carry_q)) else $error("branch touched carry"); // R6

  AST_RSV_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
    (op >= OP_RSV13) |=> $stable(carry_q)) else $error("reserved code touched carry"); // R9

endmodule

// File: rtl/branch_unit.sv
`timescale 1ns/1ps
module branch_unit
  import bitproc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic             sel_bit,
  input  logic [PC_W-1:0]  next_pc,
  input  logic [OFF_W-1:0] rel_off,
  output logic             taken,
  output logic [PC_W-1:0]  target
);
  localparam int EXT_W = PC_W - OFF_W;

  function automatic logic [PC_W-1:0] f_rel_target(logic [PC_W-1:0] pc,
                                                   logic [OFF_W-1:0] off);
    logic [PC_W-1:0] ext;
    ext = {{EXT_W{off[OFF_W-1]}}, off};
    return pc + ext;
  endfunction

  logic hit_set;
  logic hit_clr;

  assign hit_set = ((op == OP_JSET) || (op == OP_JSETC)) && sel_bit;
  assign hit_clr = (op == OP_JCLR) && !sel_bit;
  assign taken   = hit_set | hit_clr;
  assign target  = f_rel_target(next_pc, rel_off);

  AST_TAKEN_ONLY_BR: assert property (@(posedge clk) disable iff (rst)
    taken |-> f_is_branch(op)) else $error("taken on non-branch"); // R8

  AST_JCLR_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JCLR) |-> (taken != sel_bit)) else $error("clear-test polarity"); // R6

  AST_HITS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_set, hit_clr})) else $error("both hit paths"); // R6

endmodule

// File: rtl/bool_bit_engine.sv
`timescale 1ns/1ps
module bool_bit_engine
  import bitproc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PC_W   = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  input  logic [PC_W-1:0]   next_pc_i,
  input  logic [OFF_W-1:0]  rel_off_i,
  output logic              carry_o,
  output logic              wb_en_o,
  output logic              wb_bit_o,
  output logic              br_taken_o,
  output logic [PC_W-1:0]   br_target_o
);
  op_e  op;
  logic sel_bit;
  logic carry_q;
  logic store_c;
  logic jbc_clear;

  assign op = op_e'(op_i);

  bit_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (bit_addr_i),
    .rd_bit  (sel_bit),
    .wr_en   (wb_en_o),
    .wr_addr (bit_addr_i),
    .wr_bit  (wb_bit_o)
  );

  carry_unit u_carry (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .sel_bit (sel_bit),
    .carry_q (carry_q)
  );

  branch_unit #(.PC_W(PC_W), .OFF_W(OFF_W)) u_branch (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .sel_bit (sel_bit),
    .next_pc (next_pc_i),
    .rel_off (rel_off_i),
    .taken   (br_taken_o),
    .target  (br_target_o)
  );

  assign store_c   = (op == OP_STC);
  assign jbc_clear = (op == OP_JSETC) && sel_bit;
  assign wb_en_o   = store_c | jbc_clear;
  assign wb_bit_o  = store_c ? carry_q : 1'b0;
  assign carry_o   = carry_q;

  AST_JBC_ATOMIC: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JSETC) |-> (wb_en_o == br_taken_o)) else $error("test-and-clear split"); // R7

  AST_JBC_ZERO: assert property (@(posedge clk) disable iff (rst)
    jbc_clear |-> !wb_bit_o) else $error("test-and-clear wrote one"); // R7

  AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
    store_c |-> (wb_bit_o == carry_o)) else $error("store data mismatch"); // R5

  AST_WB_SOURCES: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> ((op == OP_STC) || (op == OP_JSETC))) else $error("stray write"); // R9

endmodule

// File: tb/tb_bool_bit_engine.sv
`timescale 1ns/1ps
module tb_bool_bit_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = 4'd0;
  logic [7:0]  addr = 8'd0;
  logic [15:0] pc = 16'd0;
  logic [7:0]  off = 8'd0;
  logic        carry_o, wb_en_o, wb_bit_o, br_taken_o;
  logic [15:0] br_target_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic         ref_c;
  logic [255:0] ref_bits;

  always #4 clk = ~clk;

  bool_bit_engine dut (
    .clk(clk), .rst(rst), .op_i(op), .bit_addr_i(addr), .next_pc_i(pc),
    .rel_off_i(off), .carry_o(carry_o), .wb_en_o(wb_en_o), .wb_bit_o(wb_bit_o),
    .br_taken_o(br_taken_o), .br_target_o(br_target_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One operation: check state, drive, check same-cycle outputs, update model.
  task automatic step(input string tag, input logic [3:0] o, input logic [7:0] a,
                      input logic [15:0] p, input logic [7:0] d);
    logic eb, et, ewb, ewd;
    logic [15:0] etg;
    int s;
    @(negedge clk);
    chk(carry_o == ref_c, {tag, "/R10"}, "carry", 32'(carry_o), 32'(ref_c));
    op = o; addr = a; pc = p; off = d;
    #1;
    eb  = ref_bits[a];
    et  = ((o == 4'd10) && eb) || ((o == 4'd11) && !eb) || ((o == 4'd12) && eb);
    s   = int'(p) + int'($signed(d));
    etg = s[15:0];
    ewb = (o == 4'd9) || ((o == 4'd12) && eb);
    ewd = (o == 4'd9) ? ref_c : 1'b0;
    chk(br_taken_o == et, {tag, "/R8"}, "taken", 32'(br_taken_o), 32'(et));
    chk(br_target_o == etg, {tag, "/R8"}, "target", 32'(br_target_o), 32'(etg));
    chk(wb_en_o == ewb, {tag, "/R9"}, "wb_en", 32'(wb_en_o), 32'(ewb));
    if (ewb) chk(wb_bit_o == ewd, {tag, "/R5"}, "wb_bit", 32'(wb_bit_o), 32'(ewd));
    case (o)
      4'd1: ref_c = 1'b1;
      4'd2: ref_c = 1'b0;
      4'd3: ref_c = ~ref_c;
      4'd4: ref_c = ref_c & eb;
      4'd5: ref_c = ref_c & ~eb;
      4'd6: ref_c = ref_c | eb;
      4'd7: ref_c = ref_c | ~eb;
      4'd8: ref_c = eb;
      4'd9: ref_bits[a] = ref_c;
      4'd12: if (eb) ref_bits[a] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic put_bit(input string tag, input logic [7:0] a, input logic v);
    step(tag, v ? 4'd1 : 4'd2, 8'd0, 16'd0, 8'd0);
    step(tag, 4'd9, a, 16'd0, 8'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op = 4'd0;
    @(negedge clk);
    rst = 1'b0;
    ref_c = 1'b0; ref_bits = '0;
  endtask

  task automatic t_reset();
    put_bit("R1", 8'd77, 1'b1);
    step("R1", 4'd1, 8'd0, 16'd0, 8'd0);
    do_reset();
    #1;
    chk(carry_o == 1'b0, "R1", "carry after reset", 32'(carry_o), 32'd0);
    step("R1", 4'd8, 8'd77, 16'd0, 8'd0);
    step("R1", 4'd8, 8'd0, 16'd0, 8'd0);
    step("R1", 4'd8, 8'd255, 16'd0, 8'd0);
  endtask

  task automatic t_carry_ops();
    step("R2", 4'd1, 8'd0, 16'd0, 8'd0);
    step("R2", 4'd0, 8'd0, 16'd0, 8'd0);
    step("R2", 4'd3, 8'd0, 16'd0, 8'd0);
    step("R2", 4'd3, 8'd0, 16'd0, 8'd0);
    step("R2", 4'd2, 8'd0, 16'd0, 8'd0);
    step("R2", 4'd0, 8'd0, 16'd0, 8'd0);
  endtask

  task automatic t_logic();
    put_bit("R3", 8'h10, 1'b1);
    put_bit("R3", 8'h11, 1'b0);
    for (int c = 0; c < 2; c++) begin
      for (int o = 4; o < 8; o++) begin
        step(o < 6 ? "R3" : "R4", c[0] ? 4'd1 : 4'd2, 8'd0, 16'd0, 8'd0);
        step(o < 6 ? "R3" : "R4", 4'(o), 8'h10, 16'd0, 8'd0);
        step(o < 6 ? "R3" : "R4", c[0] ? 4'd1 : 4'd2, 8'd0, 16'd0, 8'd0);
        step(o < 6 ? "R3" : "R4", 4'(o), 8'h11, 16'd0, 8'd0);
      end
    end
  endtask

  task automatic t_moves();
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a;
      a = (i == 15) ? 8'd255 : 8'(i * 17 + 3);
      if (i == 0) a = 8'd0;
      put_bit("R5", a, (i % 3) != 1);
    end
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a;
      a = (i == 15) ? 8'd255 : 8'(i * 17 + 3);
      if (i == 0) a = 8'd0;
      step("R5", 4'd8, a, 16'd0, 8'd0);
    end
  endtask

  task automatic t_tests();
    put_bit("R6", 8'h40, 1'b1);
    put_bit("R6", 8'h41, 1'b0);
    step("R6", 4'd1, 8'd0, 16'd0, 8'd0);
    step("R6", 4'd10, 8'h40, 16'h1000, 8'h05);
    step("R6", 4'd10, 8'h41, 16'h1000, 8'h05);
    step("R6", 4'd11, 8'h40, 16'h2000, 8'hF0);
    step("R6", 4'd11, 8'h41, 16'h2000, 8'hF0);
    step("R6", 4'd8, 8'h40, 16'd0, 8'd0);
    step("R6", 4'd8, 8'h41, 16'd0, 8'd0);
  endtask

  task automatic t_test_clear();
    put_bit("R7", 8'h80, 1'b1);
    step("R7", 4'd12, 8'h80, 16'h0300, 8'h7F);
    step("R7", 4'd12, 8'h80, 16'h0300, 8'h7F);
    step("R7", 4'd10, 8'h80, 16'h0300, 8'h7F);
    step("R7", 4'd8, 8'h80, 16'd0, 8'd0);
    put_bit("R7", 8'h81, 1'b0);
    step("R7", 4'd1, 8'd0, 16'd0, 8'd0);
    step("R7", 4'd12, 8'h81, 16'h0300, 8'h80);
    step("R7", 4'd8, 8'h81, 16'd0, 8'd0);
  endtask

  task automatic t_targets();
    step("R8", 4'd0, 8'd0, 16'hFFF0, 8'h20);
    step("R8", 4'd0, 8'd0, 16'h0005, 8'hF0);
    step("R8", 4'd0, 8'd0, 16'h1234, 8'h80);
    step("R8", 4'd0, 8'd0, 16'h1234, 8'h7F);
    step("R8", 4'd4, 8'd0, 16'hABCD, 8'hFF);
  endtask

  task automatic t_reserved();
    put_bit("R9", 8'h22, 1'b1);
    step("R9", 4'd1, 8'd0, 16'd0, 8'd0);
    for (int o = 13; o < 16; o++) step("R9", 4'(o), 8'h22, 16'h0100, 8'h10);
    step("R9", 4'd2, 8'd0, 16'd0, 8'd0);
    for (int o = 13; o < 16; o++) step("R9", 4'(o), 8'h22, 16'h0100, 8'h10);
    step("R9", 4'd8, 8'h22, 16'd0, 8'd0);
  endtask

  initial begin
    ref_c = 1'b0; ref_bits = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_carry_ops();
    t_logic();
    t_moves();
    t_tests();
    t_test_clear();
    t_targets();
    t_reserved();
    step("R10", 4'd0, 8'd0, 16'd0, 8'd0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule